// File: doc/BRIEF.md
# Per-Channel Interrupt Cause Aggregator

This block gathers the interrupt causes of a multi-channel streaming DMA engine and folds them into one interrupt line per destination. Every channel owns two cause flags: a completion flag and an error flag. A one-cycle event pulse from the channel raises a flag. It holds until software writes a 1 to it.

Each channel has its own copy of the cause flags and of an enable mask for every destination. Several interrupt controllers can therefore watch the same channels, and each one is acknowledged and masked independently. A flag counts only while its enable bit is set. For each destination, the enabled causes of the even (memory-to-device) channels fill a transmit summary word, and those of the odd (device-to-memory) channels fill a receive summary word. Both words are indexed by channel number divided by two. A destination's interrupt line is raised whenever either of its summary words is non-zero.

Software reaches every flag, mask and summary word through a simple single-cycle register port. Reads return data one cycle later.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, every cause flag, every enable mask, every summary word and every `irq_out` bit is zero.
- R2: A pulse on `evt_done[c]` or `evt_err[c]` sets, on the next clock edge, the completion flag (read bit 0) or the error flag (read bit 6) of channel c in the flag register of every destination.
- R3: A write to a flag register clears each flag whose data bit (bit 0 completion, bit 6 error) is 1, and leaves the flags whose data bit is 0 unchanged.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A mask write stores data bits 0 and 6 as the enables of the completion and error causes. A cause whose enable is 0 adds nothing to any summary word or to `irq_out`.
- R6: In destination d, an enabled, set cause of an even channel c sets bit c/2 of the transmit summary word. For an odd channel c it sets bit c/2 of the receive summary word.
- R7: `irq_out[d]` is 1 exactly when the transmit or the receive summary word of destination d is non-zero.
- R8: Flag clears and mask writes in one destination leave the flags, masks, summaries and interrupt line of every other destination unchanged.
- R9: The address is {space, channel[5:0], kind, dest[1:0]}, with space in the top bit. Space 0 selects a per-channel register, where kind 0 is the flag register and kind 1 is the mask register. Space 1 selects a summary word, where kind 0 is transmit and kind 1 is receive, and the channel field is ignored.
- R10: Read data appears on `reg_rdata` in the cycle after the read request. Bits other than 0 and 6 of a per-channel register read as 0. Writes to the summary space change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_done | input | NUM_CH | Per-channel completion event pulses |
| evt_err | input | NUM_CH | Per-channel error event pulses |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | AW (10) | Register word address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, one cycle after the request |
| irq_out | output | NUM_DEST | Interrupt line per destination |

## Verification
The hardest case to reach from the ports is a hardware event and a software clear landing on the same flag in the same cycle. The bench drives that case by pulsing the event on the same falling edge that presents the clearing write, so both are sampled at one rising edge.

Cross-destination isolation is also easy to miss. The bench therefore enables causes in one destination only, acknowledges them there, and then reads the same channel through another destination to show its flag is still set.

The channel-pair indexing is checked at both ends of the range: channel 0 lands in transmit bit 0 and channel 63 in receive bit 31.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Bit positions software decodes in per-channel registers
    localparam int DONE_BIT = 0;
    localparam int ERR_BIT  = 6;

    typedef enum logic {
        SPACE_CHAN = 1'b0,
        SPACE_SUM  = 1'b1
    } space_e;

    typedef enum logic {
        KIND_FLAG = 1'b0,
        KIND_MASK = 1'b1
    } kind_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

endpackage

// File: rtl/irqagg_cause_cell.sv
module irqagg_cause_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_done,
    input  logic evt_err,
    input  logic wr_flag,
    input  logic wr_mask,
    input  logic wd_done,
    input  logic wd_err,
    output logic flag_done,
    output logic flag_err,
    output logic en_done,
    output logic en_err,
    output logic pend
);

    logic clr_done;
    logic clr_err;

    always_comb begin
        clr_done = wr_flag & wd_done;
        clr_err  = wr_flag & wd_err;
    end

    // Event wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_done <= 1'b0;
            flag_err  <= 1'b0;
        end else begin
            flag_done <= evt_done | (flag_done & ~clr_done);
            flag_err  <= evt_err  | (flag_err  & ~clr_err);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_done <= 1'b0;
            en_err  <= 1'b0;
        end else if (wr_mask) begin
            en_done <= wd_done;
            en_err  <= wd_err;
        end
    end

    always_comb begin
        pend = (flag_done & en_done) | (flag_err & en_err);
    end

endmodule

// File: rtl/irqagg_pair_fold.sv
module irqagg_pair_fold #(
    parameter int NUM_CH = 64
) (
    input  logic [NUM_CH-1:0]   pend,
    output logic [NUM_CH/2-1:0] tx_word,
    output logic [NUM_CH/2-1:0] rx_word
);

    localparam int PAIRS = NUM_CH / 2;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign tx_word[p] = pend[2*p];
        assign rx_word[p] = pend[2*p+1];
    end

endmodule

// File: rtl/irqagg_regport.sv
module irqagg_regport
    import irqagg_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int NUM_DEST = 4,
    parameter int DATA_W   = 32,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int DEST_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    parameter int AW       = 1 + CH_W + 1 + DEST_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reg_en,
    input  logic                                reg_we,
    input  logic [AW-1:0]                       reg_addr,
    input  logic [DATA_W-1:0]                   reg_wdata,
    input  logic [NUM_DEST-1:0][NUM_CH-1:0]     flag_done,
    input  logic [NUM_DEST-1:0][NUM_CH-1:0]     flag_err,
    input  logic [NUM_DEST-1:0][NUM_CH-1:0]     en_done,
    input  logic [NUM_DEST-1:0][NUM_CH-1:0]     en_err,
    input  logic [NUM_DEST-1:0][NUM_CH/2-1:0]   tx_sum,
    input  logic [NUM_DEST-1:0][NUM_CH/2-1:0]   rx_sum,
    output logic [NUM_DEST-1:0][NUM_CH-1:0]     wr_flag,
    output logic [NUM_DEST-1:0][NUM_CH-1:0]     wr_mask,
    output logic                                wd_done,
    output logic                                wd_err,
    output logic [DATA_W-1:0]                   reg_rdata
);

    localparam int SUM_W = NUM_CH / 2;

    space_e            space;
    kind_e             kind;
    logic [CH_W-1:0]   ch_idx;
    logic [DEST_W-1:0] dest_idx;
    logic              ch_ok;
    logic              dest_ok;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        space    = space_e'(reg_addr[AW-1]);
        kind     = kind_e'(reg_addr[DEST_W]);
        ch_idx   = reg_addr[DEST_W+1 +: CH_W];
        dest_idx = reg_addr[DEST_W-1:0];
        ch_ok    = int'(ch_idx) < NUM_CH;
        dest_ok  = int'(dest_idx) < NUM_DEST;
        wd_done  = reg_wdata[DONE_BIT];
        wd_err   = reg_wdata[ERR_BIT];
    end

    always_comb begin
        wr_flag = '0;
        wr_mask = '0;
        if (reg_en && reg_we && space == SPACE_CHAN && ch_ok && dest_ok) begin
            unique case (kind)
                KIND_FLAG: wr_flag[dest_idx][ch_idx] = 1'b1;
                KIND_MASK: wr_mask[dest_idx][ch_idx] = 1'b1;
            endcase
        end
    end

    always_comb begin
        rd_next = '0;
        if (dest_ok) begin
            unique case (space)
                SPACE_CHAN: begin
                    if (ch_ok) begin
                        unique case (kind)
                            KIND_FLAG: begin
                                rd_next[DONE_BIT] = flag_done[dest_idx][ch_idx];
                                rd_next[ERR_BIT]  = flag_err[dest_idx][ch_idx];
                            end
                            KIND_MASK: begin
                                rd_next[DONE_BIT] = en_done[dest_idx][ch_idx];
                                rd_next[ERR_BIT]  = en_err[dest_idx][ch_idx];
                            end
                        endcase
                    end
                end
                SPACE_SUM: begin
                    if (dir_e'(kind) == DIR_RX)
                        rd_next[SUM_W-1:0] = rx_sum[dest_idx];
                    else
                        rd_next[SUM_W-1:0] = tx_sum[dest_idx];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_en && !reg_we)
            reg_rdata <= rd_next;
        else
            reg_rdata <= '0;
    end

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irqagg_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int NUM_DEST = 4,
    parameter int DATA_W   = 32,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int DEST_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    parameter int AW       = 1 + CH_W + 1 + DEST_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   evt_done,
    input  logic [NUM_CH-1:0]   evt_err,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_DEST-1:0] irq_out
);

    localparam int SUM_W = NUM_CH / 2;

    logic [NUM_DEST-1:0][NUM_CH-1:0] flag_done;
    logic [NUM_DEST-1:0][NUM_CH-1:0] flag_err;
    logic [NUM_DEST-1:0][NUM_CH-1:0] en_done;
    logic [NUM_DEST-1:0][NUM_CH-1:0] en_err;
    logic [NUM_DEST-1:0][NUM_CH-1:0] pend;
    logic [NUM_DEST-1:0][NUM_CH-1:0] wr_flag;
    logic [NUM_DEST-1:0][NUM_CH-1:0] wr_mask;
    logic [NUM_DEST-1:0][SUM_W-1:0]  tx_sum;
    logic [NUM_DEST-1:0][SUM_W-1:0]  rx_sum;
    logic                            wd_done;
    logic                            wd_err;

    irqagg_regport #(
        .NUM_CH   (NUM_CH),
        .NUM_DEST (NUM_DEST),
        .DATA_W   (DATA_W),
        .CH_W     (CH_W),
        .DEST_W   (DEST_W),
        .AW       (AW)
    ) u_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flag_done (flag_done),
        .flag_err  (flag_err),
        .en_done   (en_done),
        .en_err    (en_err),
        .tx_sum    (tx_sum),
        .rx_sum    (rx_sum),
        .wr_flag   (wr_flag),
        .wr_mask   (wr_mask),
        .wd_done   (wd_done),
        .wd_err    (wd_err),
        .reg_rdata (reg_rdata)
    );

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            irqagg_cause_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt_done  (evt_done[c]),
                .evt_err   (evt_err[c]),
                .wr_flag   (wr_flag[d][c]),
                .wr_mask   (wr_mask[d][c]),
                .wd_done   (wd_done),
                .wd_err    (wd_err),
                .flag_done (flag_done[d][c]),
                .flag_err  (flag_err[d][c]),
                .en_done   (en_done[d][c]),
                .en_err    (en_err[d][c]),
                .pend      (pend[d][c])
            );
        end

        irqagg_pair_fold #(
            .NUM_CH (NUM_CH)
        ) u_fold (
            .pend    (pend[d]),
            .tx_word (tx_sum[d]),
            .rx_word (rx_sum[d])
        );

        assign irq_out[d] = (|tx_sum[d]) | (|rx_sum[d]);
    end

endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
    parameter int NUM_CH   = 64,
    parameter int NUM_DEST = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CH-1:0]               evt_done,
    input logic [NUM_CH-1:0]               evt_err,
    input logic [NUM_DEST-1:0]             irq_out,
    input logic [NUM_DEST-1:0][NUM_CH-1:0] flag_done,
    input logic [NUM_DEST-1:0][NUM_CH-1:0] flag_err,
    input logic [NUM_DEST-1:0][NUM_CH-1:0] en_done,
    input logic [NUM_DEST-1:0][NUM_CH-1:0] en_err
);

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_d
        // R2 R4
        done_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_done != '0) |=> ((flag_done[d] & $past(evt_done)) == $past(evt_done)));

        // R2 R4
        err_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_err != '0) |=> ((flag_err[d] & $past(evt_err)) == $past(evt_err)));

        // R2
        done_rise_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((flag_done[d] & ~$past(flag_done[d]) & ~$past(evt_done)) == '0));

        // R5
        irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[d] |-> ((en_done[d] | en_err[d]) != '0));

        // R7
        irq_tracks_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (((flag_done[d] & en_done[d]) | (flag_err[d] & en_err[d])) != '0) |-> irq_out[d]);
    end

endmodule

bind irq_status_agg irq_status_agg_chk #(
    .NUM_CH   (NUM_CH),
    .NUM_DEST (NUM_DEST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_done  (evt_done),
    .evt_err   (evt_err),
    .irq_out   (irq_out),
    .flag_done (flag_done),
    .flag_err  (flag_err),
    .en_done   (en_done),
    .en_err    (en_err)
);

// File: tb/irq_status_agg_test.sv
module irq_status_agg_test;

    localparam int NUM_CH   = 64;
    localparam int NUM_DEST = 4;
    localparam int DATA_W   = 32;
    localparam int AW       = 10;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_CH-1:0]   evt_done = '0;
    logic [NUM_CH-1:0]   evt_err = '0;
    logic                reg_en = 1'b0;
    logic                reg_we = 1'b0;
    logic [AW-1:0]       reg_addr = '0;
    logic [DATA_W-1:0]   reg_wdata = '0;
    logic [DATA_W-1:0]   reg_rdata;
    logic [NUM_DEST-1:0] irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    logic              fire = 1'b0;

    always #4 clk = ~clk;

    irq_status_agg uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_done  (evt_done),
        .evt_err   (evt_err),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    // R9 address layout
    function automatic logic [AW-1:0] chan_addr(int ch, int kind, int dest);
        return {1'b0, 6'(ch), 1'(kind), 2'(dest)};
    endfunction

    function automatic logic [AW-1:0] sum_addr(int dir, int dest);
        return {1'b1, 6'd0, 1'(dir), 2'(dest)};
    endfunction

    // Monitor: compare read data against scoreboard
    always @(posedge clk) fire <= reg_en && !reg_we;

    always @(negedge clk) begin
        if (fire) begin
            logic [DATA_W-1:0] e;
            string t;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R10: unexpected read data act=%h exp=none", reg_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_fails++;
                    $display("FAIL %s: read act=%h exp=%h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DATA_W-1:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic pulse(input int ch, input bit is_err);
        @(negedge clk);
        if (is_err) evt_err[ch] = 1'b1; else evt_done[ch] = 1'b1;
        @(negedge clk);
        evt_done = '0; evt_err = '0;
    endtask

    task automatic chk_irq(input logic [NUM_DEST-1:0] e, input string t);
        n_checks++;
        if (irq_out !== e) begin
            n_fails++;
            $display("FAIL %s: irq_out act=%b exp=%b", t, irq_out, e);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_irq(4'b0000, "R1");
        rd(chan_addr(5, 0, 0), 32'h0, "R1");
        rd(chan_addr(5, 1, 2), 32'h0, "R1");
        rd(sum_addr(0, 3), 32'h0, "R1");
        rd(sum_addr(1, 0), 32'h0, "R1");

        // R2 completion on channel 5 reaches every destination
        pulse(5, 1'b0);
        for (int d = 0; d < NUM_DEST; d++) rd(chan_addr(5, 0, d), 32'h1, "R2");
        chk_irq(4'b0000, "R5");
        rd(sum_addr(1, 1), 32'h0, "R5");

        // R5/R6/R7 enable in destination 1: odd channel 5 -> rx bit 2
        wr(chan_addr(5, 1, 1), 32'h41);
        rd(chan_addr(5, 1, 1), 32'h41, "R5");
        rd(sum_addr(1, 1), 32'h4, "R6");
        rd(sum_addr(0, 1), 32'h0, "R6");
        chk_irq(4'b0010, "R7");

        // R2/R6 error on even channel 10 -> tx bit 5 in destination 2
        pulse(10, 1'b1);
        for (int d = 0; d < NUM_DEST; d++) rd(chan_addr(10, 0, d), 32'h40, "R2");
        wr(chan_addr(10, 1, 2), 32'h40);
        rd(sum_addr(0, 2), 32'h20, "R6");
        chk_irq(4'b0110, "R7");

        // R5 enabling only the other cause removes the contribution
        wr(chan_addr(10, 1, 2), 32'h01);
        rd(sum_addr(0, 2), 32'h0, "R5");
        chk_irq(4'b0010, "R5");

        // R3 write-one-to-clear, zero bits untouched
        wr(chan_addr(5, 0, 1), 32'h40);
        rd(chan_addr(5, 0, 1), 32'h1, "R3");
        chk_irq(4'b0010, "R3");
        wr(chan_addr(5, 0, 1), 32'h01);
        rd(chan_addr(5, 0, 1), 32'h0, "R3");
        chk_irq(4'b0000, "R3");
        // R8 other destinations keep their flag
        rd(chan_addr(5, 0, 0), 32'h1, "R8");
        rd(chan_addr(5, 0, 3), 32'h1, "R8");

        // R6 upper boundary: channel 63 -> rx bit 31
        pulse(63, 1'b0);
        wr(chan_addr(63, 1, 3), 32'h01);
        rd(sum_addr(1, 3), 32'h8000_0000, "R6");
        chk_irq(4'b1000, "R7");

        // R4 event and clear collide on the same edge
        @(negedge clk);
        evt_done[63] = 1'b1;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = chan_addr(63, 0, 3); reg_wdata = 32'h41;
        @(negedge clk);
        evt_done = '0; reg_en = 1'b0; reg_we = 1'b0;
        rd(chan_addr(63, 0, 3), 32'h1, "R4");
        chk_irq(4'b1000, "R4");
        wr(chan_addr(63, 0, 3), 32'h01);
        rd(chan_addr(63, 0, 3), 32'h0, "R3");
        chk_irq(4'b0000, "R3");

        // R6 lower boundary: channel 0 -> tx bit 0
        pulse(0, 1'b1);
        wr(chan_addr(0, 1, 0), 32'h40);
        rd(sum_addr(0, 0), 32'h1, "R6");
        chk_irq(4'b0001, "R7");

        // R10 summary space ignores writes; reserved bits read zero
        wr(sum_addr(0, 0), 32'h0);
        rd(sum_addr(0, 0), 32'h1, "R10");
        chk_irq(4'b0001, "R10");
        wr(chan_addr(1, 1, 0), 32'hFFFF_FFFF);
        rd(chan_addr(1, 1, 0), 32'h41, "R10");

        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R10: pending reads act=%0d exp=0", exp_q.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule